// File: doc/BRIEF.md
# Watchdog Timer with Interrupt Option

The block is a supervisory timer fed by a slow tick enable. Software programs an 8-bit control register. Once the watchdog is enabled, each tick advances a counter. If software does not refresh it within the selected period, the block expires. On expiry it either emits a one-cycle reset pulse for the system or raises a level interrupt request. The choice is made by an interrupt-mode bit.

The control register is guarded against stray writes. A write with the unlock bit set opens the register. The next write, whatever it holds, is applied and closes it again. That applied write restarts the counter, and when its enable bit is 1 this acts as the refresh. A select code of 8 forces a reset at once. Codes above 8 behave as the longest period.

The register port is a plain strobe with combinational read data and no back-pressure: a write is taken on every clock edge where `reg_wr_i` is high. The tick, reset and interrupt pins are plain control lines.

Top module: `wdt_top`

## Requirements
- R1: After power-on reset the register reads 0x00, and both `wdt_reset_o` and `wdt_irq_o` are low.
- R2: Register layout: bits [7:4] are the period select, bit 3 is interrupt mode, bit 2 is the expiry flag, bit 1 is enable, and bit 0 reads back as 1 while the register is open.
- R3: While the register is closed, a write with bit 0 = 0 changes nothing. A write with bit 0 = 1 only opens the register.
- R4: While the register is open, the next write is applied in full and closes the register. A further write without unlocking is ignored.
- R5: With select code k in 0..7, the watchdog expires on the (BASE_TICKS << k)-th tick after the applied write that enabled it.
- R6: Select codes 9..15 give a period of BASE_TICKS << 7 ticks.
- R7: With enable set, select code 8 produces one reset pulse in the cycle after the write, clears the enable bit and sets the expiry flag.
- R8: In reset mode, expiry drives `wdt_reset_o` high for exactly one cycle. The pulse starts in the cycle after the clock edge that samples the expiring tick.
- R9: In interrupt mode, expiry gives no reset pulse. It sets the flag, `wdt_irq_o` equals flag AND interrupt mode, and counting starts over.
- R10: The expiry flag stays set until an applied write carries 0 in bit 2. Writing 1 there leaves the flag unchanged.
- R11: An applied write with enable = 1 (refresh) restarts the full period. Without ticks, or with enable = 0, no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| tick_i | input | 1 | Slow timebase enable, one cycle per tick |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| wdt_reset_o | output | 1 | One-cycle system reset request |
| wdt_irq_o | output | 1 | Level interrupt request |

## Verification
The assertions take for granted that `rst_n` is the power-on reset and is not driven by `wdt_reset_o`. Otherwise a sticky flag and a one-cycle pulse could not be observed. They also assume that a tick and a register write may land in the same cycle, with the applied write taking precedence over counting. The stimulus keeps ticks and writes in separate cycles, so each measured period is an exact tick count. It drives every input at the falling edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [3:0] SEL_IMMEDIATE = 4'd8;

  typedef struct packed {
    logic [3:0] sel;
    logic       irq_mode;
    logic       flag;
    logic       enable;
    logic       open;
  } wdt_cfg_t;

  function automatic int unsigned wdt_limit(input logic [3:0] sel, input int unsigned base);
    if (sel < 4'd8) return base << sel;
    return base << 7;
  endfunction
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       expire_i,
  input  logic       immediate_i,
  output wdt_cfg_t   cfg_o,
  output logic       cfg_wr_o
);
  wdt_cfg_t cfg_q;
  wdt_cfg_t wcfg;

  assign wcfg     = wdt_cfg_t'(wdata_i);
  assign cfg_wr_o = wr_i && cfg_q.open;
  assign cfg_o    = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      if (cfg_wr_o) begin
        cfg_q.sel      <= wcfg.sel;
        cfg_q.irq_mode <= wcfg.irq_mode;
        cfg_q.enable   <= wcfg.enable;
        cfg_q.open     <= 1'b0;
        cfg_q.flag     <= (cfg_q.flag && wcfg.flag) || expire_i || immediate_i;
      end else begin
        if (wr_i && wcfg.open) cfg_q.open <= 1'b1;
        if (immediate_i) cfg_q.enable <= 1'b0;
        if (expire_i || immediate_i) cfg_q.flag <= 1'b1;
      end
    end
  end

  assert_locked_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !cfg_q.open) |=> ($stable(cfg_q.sel) && $stable(cfg_q.enable) && $stable(cfg_q.irq_mode)));
  assert_write_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_o |=> !cfg_q.open);
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.flag && !cfg_wr_o) |=> cfg_q.flag);
  assert_immediate_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (immediate_i && !cfg_wr_o) |=> (!cfg_q.enable && cfg_q.flag));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       enable_i,
  input  logic [3:0] sel_i,
  input  logic       restart_i,
  output logic       expire_o,
  output logic       immediate_o
);
  localparam int unsigned MAX_LIMIT = BASE_TICKS << 7;
  localparam int unsigned CW = $clog2(MAX_LIMIT) + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit       = CW'(wdt_limit(sel_i, BASE_TICKS));
  assign immediate_o = enable_i && (sel_i == SEL_IMMEDIATE) && !restart_i;
  assign expire_o    = enable_i && tick_i && !restart_i && !immediate_o
                       && (cnt_q == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!enable_i || restart_i || expire_o) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CW'(1);
  end

  assert_count_below_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < limit);
  assert_idle_when_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       wdt_reset_o,
  output logic       wdt_irq_o
);
  wdt_cfg_t cfg;
  logic     cfg_wr, expire, immediate;
  logic     rst_q;

  wdt_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
    .expire_i(expire), .immediate_i(immediate), .cfg_o(cfg), .cfg_wr_o(cfg_wr)
  );

  wdt_counter #(.BASE_TICKS(BASE_TICKS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .enable_i(cfg.enable),
    .sel_i(cfg.sel), .restart_i(cfg_wr), .expire_o(expire), .immediate_o(immediate)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= immediate || (expire && !cfg.irq_mode);
  end

  assign reg_rdata_o = cfg;
  assign wdt_reset_o = rst_q;
  assign wdt_irq_o   = cfg.flag && cfg.irq_mode;

  assert_reset_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_o |=> !wdt_reset_o);
  assert_irq_mode_no_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && cfg.irq_mode) |=> !wdt_reset_o);
  assert_reset_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_o |-> cfg.flag);
endmodule

// File: tb/wdt_top_tb_top.sv
module wdt_top_tb_top;
  localparam int BASE = 2;
  logic clk = 0, rst_n = 0, tick = 0, wr = 0;
  logic [7:0] wdata = 0, rdata;
  logic wrst, wirq;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  wdt_top #(.BASE_TICKS(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .wdt_reset_o(wrst), .wdt_irq_o(wirq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d);
    @(negedge clk); wr = 1; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic cfg_write(input logic [3:0] sel, input logic irqm, input logic flg, input logic en);
    wr_reg(8'h01);
    wr_reg({sel, irqm, flg, en, 1'b0});
  endtask

  // tick until reset or flag-raised irq event; returns tick count (0 = none within max)
  task automatic count_ticks(input int maxt, input bit use_irq, output int n);
    n = 0;
    for (int i = 1; i <= maxt; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      if ((use_irq ? wirq : wrst) === 1'b1) begin n = i; break; end
    end
  endtask

  int n;
  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rdata", rdata, 0);
    chk("R1 reset", wrst, 0);
    chk("R1 irq", wirq, 0);

    // R3: closed register ignores write without unlock
    wr_reg(8'hF2);
    chk("R3 locked write", rdata, 0);
    wr_reg(8'h01);
    chk("R3 open bit R2", rdata, 8'h01);
    // R4: next write applied and closes
    wr_reg(8'h58);
    chk("R4 applied", rdata, 8'h58);
    wr_reg(8'h32);
    chk("R4 reclosed", rdata, 8'h58);

    // R5/R8: sweep codes 0..7 in reset mode
    for (int k = 0; k < 8; k++) begin
      cfg_write(4'(k), 1'b0, 1'b0, 1'b1);
      count_ticks(BASE << 8, 0, n);
      chk($sformatf("R5 period code %0d", k), n, BASE << k);
      @(negedge clk);
      chk("R8 pulse width", wrst, 0);
      chk("R10 flag set", rdata[2], 1);
    end
    // R6: reserved codes
    for (int k = 9; k < 16; k++) begin
      cfg_write(4'(k), 1'b0, 1'b0, 1'b1);
      count_ticks(BASE << 8, 0, n);
      chk($sformatf("R6 period code %0d", k), n, BASE << 7);
    end

    // R10: writing 1 to flag keeps it, 0 clears it
    cfg_write(4'd0, 1'b0, 1'b1, 1'b0);
    chk("R10 flag kept", rdata[2], 1);
    cfg_write(4'd0, 1'b0, 1'b0, 1'b0);
    chk("R10 flag cleared", rdata[2], 0);

    // R11: disabled watchdog never expires
    count_ticks(BASE * 4, 0, n);
    chk("R11 disabled", n, 0);

    // R11: refresh restarts the period
    cfg_write(4'd2, 1'b0, 1'b0, 1'b1);
    count_ticks((BASE << 2) - 1, 0, n);
    chk("R11 before refresh", n, 0);
    cfg_write(4'd2, 1'b0, 1'b0, 1'b1);
    count_ticks(BASE << 3, 0, n);
    chk("R11 full period after refresh", n, BASE << 2);

    // R9: interrupt mode
    for (int k = 0; k < 4; k++) begin
      cfg_write(4'(k), 1'b1, 1'b0, 1'b1);
      chk("R9 irq low before", wirq, 0);
      count_ticks(BASE << 8, 1, n);
      chk($sformatf("R9 irq period code %0d", k), n, BASE << k);
      chk("R9 no reset", wrst, 0);
    end
    // R9: counting restarts, second period yields no reset pulse
    begin
      int seen = 0;
      for (int i = 0; i < (BASE << 3) * 2; i++) begin
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
        if (wrst) seen = 1;
      end
      chk("R9 no reset in irq mode", seen, 0);
      chk("R9 irq level held", wirq, 1);
    end

    // R7: immediate reset code
    cfg_write(4'd8, 1'b0, 1'b0, 1'b1);
    chk("R7 not yet", wrst, 0);
    @(negedge clk);
    chk("R7 pulse", wrst, 1);
    chk("R7 enable cleared", rdata[1], 0);
    chk("R7 flag", rdata[2], 1);
    @(negedge clk);
    chk("R7 single pulse", wrst, 0);
    @(negedge clk);
    chk("R7 stays low", wrst, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule